// File: doc/BRIEF.md
# Handshaking Parallel Port Block

This block holds two byte-wide parallel ports (A and B) and a six-bit port C. A command register outside the block supplies its configuration: a direction bit for A and for B, a two-bit port C mode, and an interrupt enable for A and for B. The bus side reaches each port register through single-cycle read and write strobes that share one write data byte. The pin side exposes the pin values and output enables.

In basic operation a port simply passes pins to the bus or latch contents to the pins. When the port C mode hands some port C pins over to A, or to both A and B, those ports become handshaken. An active-low strobe from the peripheral, arriving on a port C pin, either captures incoming data or acknowledges outgoing data. A buffer-full flag and an interrupt request then track the transfer, and both also appear on port C pins. The strobe pins are passed through a two-stage synchroniser before their edges are used.

Top module: `pport_hs`

## Requirements
- R1: With a port not handshaken and its direction bit 0, its read data equals its input pins in the same cycle and its output enables are all 0.
- R2: With a direction bit of 1, a write strobe loads the write data into the port's output latch; from the next cycle its pins show the latch, all its output enables are 1 and its read data returns the latch.
- R3: Port C mode 2'b00 makes all six port C pins inputs (enables 0, read data equals the pins); mode 2'b11 makes all six outputs driven from the port C latch, which the port C write strobe loads from write data bits 5:0.
- R4: Mode 2'b01 gives port A its handshake: PC0 carries A's interrupt, PC1 A's buffer-full, PC2 is A's strobe input, and PC3 to PC5 are outputs from the port C latch (enables 6'b111011).
- R5: Mode 2'b10 gives PC0 to PC2 the same roles as in R4, and PC3 carries B's interrupt, PC4 B's buffer-full and PC5 is B's strobe input (enables 6'b011011).
- R6: A handshaken input port captures its pins and sets buffer-full on the falling strobe edge, seen three clock edges after the pin falls; the read data then returns the captured value regardless of later pin changes.
- R7: On a handshaken port the rising strobe edge sets the interrupt request; the interrupt output is the request gated by the enable bit.
- R8: A read of a handshaken input port clears its buffer-full flag and its interrupt request.
- R9: On a handshaken output port a write sets buffer-full and clears the request; a falling strobe edge clears buffer-full and the following rising edge sets the request.
- R10: Clearing an interrupt enable masks the interrupt output but keeps the request, so setting it again restores the output without a new strobe.
- R11: Reset clears every output latch, capture latch, buffer-full flag and interrupt request.
- R12: A port that is not handshaken keeps both flags at 0 and ignores activity on the port C pin that would be its strobe.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_a | input | 1 | Port A direction, 1 = output |
| cfg_dir_b | input | 1 | Port B direction, 1 = output |
| cfg_pc_mode | input | 2 | Port C mode |
| cfg_ien_a | input | 1 | Port A interrupt enable |
| cfg_ien_b | input | 1 | Port B interrupt enable |
| wr_a | input | 1 | Write strobe, port A register |
| wr_b | input | 1 | Write strobe, port B register |
| wr_c | input | 1 | Write strobe, port C register |
| rd_a | input | 1 | Read strobe, port A register |
| rd_b | input | 1 | Read strobe, port B register |
| wdata | input | 8 | Shared write data |
| pa_in | input | 8 | Port A pin inputs |
| pb_in | input | 8 | Port B pin inputs |
| pc_in | input | 6 | Port C pin inputs |
| rdata_a | output | 8 | Port A read value |
| rdata_b | output | 8 | Port B read value |
| rdata_c | output | 6 | Port C read value |
| pa_out | output | 8 | Port A pin outputs |
| pa_oe | output | 8 | Port A output enables |
| pb_out | output | 8 | Port B pin outputs |
| pb_oe | output | 8 | Port B output enables |
| pc_out | output | 6 | Port C pin outputs |
| pc_oe | output | 6 | Port C output enables |
| bf_a | output | 1 | Port A buffer-full flag |
| bf_b | output | 1 | Port B buffer-full flag |
| intr_a | output | 1 | Port A interrupt |
| intr_b | output | 1 | Port B interrupt |

## Verification
The assertions assume the read and write strobes are single-cycle pulses and that a port's input pins stay stable from the strobe's fall until the capture, which lands three edges later. They also assume the configuration is held steady across a handshake, since a mode change clears the flags. The stimulus changes pins and configuration only in the middle of a cycle. It holds each strobe level for four cycles so that every edge passes the synchroniser, and it changes pin data only after buffer-full is seen.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PC_W = 6;

  typedef enum logic [1:0] {
    PCM_IN    = 2'b00,
    PCM_A_HS  = 2'b01,
    PCM_AB_HS = 2'b10,
    PCM_OUT   = 2'b11
  } pc_mode_e;

  // Port A handshakes in both control modes
  function automatic logic a_hs(input pc_mode_e m);
    return (m == PCM_A_HS) || (m == PCM_AB_HS);
  endfunction

  function automatic logic b_hs(input pc_mode_e m);
    return (m == PCM_AB_HS);
  endfunction

  // Output enables of port C per mode (strobe pins are inputs)
  function automatic logic [PC_W-1:0] pc_dir(input pc_mode_e m);
    case (m)
      PCM_IN:   return '0;
      PCM_A_HS: return 6'b111011;
      PCM_AB_HS: return 6'b011011;
      default:  return '1;
    endcase
  endfunction
endpackage

// File: rtl/stb_sync.sv
module stb_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_n,
  output logic stb_fall,
  output logic stb_rise
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SYNC_N-1:0], stb_n};
  end

  // sh_q[SYNC_N-1] is the synchronised level, sh_q[SYNC_N] its previous value
  assign stb_fall = sh_q[SYNC_N] & ~sh_q[SYNC_N-1];
  assign stb_rise = ~sh_q[SYNC_N] & sh_q[SYNC_N-1];
endmodule

// File: rtl/hs_port.sv
module hs_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobed,
  input  logic         dir_out,
  input  logic         ien,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  input  logic         stb_fall,
  input  logic         stb_rise,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rdata,
  output logic         bf,
  output logic         intr
);
  logic [W-1:0] out_q, in_q;
  logic         bf_q, req_q;

  // named handshake events
  logic ev_load, ev_done_in, ev_rd, ev_wr_out, ev_ack, ev_ack_end;
  assign ev_load    = strobed & ~dir_out & stb_fall;
  assign ev_done_in = strobed & ~dir_out & stb_rise;
  assign ev_rd      = strobed & ~dir_out & rd;
  assign ev_wr_out  = strobed &  dir_out & wr;
  assign ev_ack     = strobed &  dir_out & ~wr & stb_fall;
  assign ev_ack_end = strobed &  dir_out & ~wr & stb_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
      bf_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (wr)      out_q <= wdata;
      if (ev_load) in_q  <= pin_in;
      if (!strobed) begin
        bf_q  <= 1'b0;
        req_q <= 1'b0;
      end else begin
        if (ev_load) bf_q <= 1'b1;
        if (ev_done_in || ev_ack_end) req_q <= 1'b1;
        if (ev_ack) bf_q <= 1'b0;
        if (ev_wr_out) begin
          bf_q  <= 1'b1;
          req_q <= 1'b0;
        end
        if (ev_rd) begin
          bf_q  <= 1'b0;
          req_q <= 1'b0;
        end
      end
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = {W{dir_out}};
  assign rdata   = dir_out ? out_q : (strobed ? in_q : pin_in);
  assign bf      = bf_q;
  assign intr    = req_q & ien;

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load && !rd |=> bf_q && (in_q == $past(pin_in)));
  p_bf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bf_q) |-> $past(ev_load || ev_wr_out));
  p_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> !bf_q && !req_q);
  p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_out |=> bf_q && !req_q);
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> !bf_q);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !strobed |=> !bf_q && !req_q);
endmodule

// File: rtl/pc_mux.sv
module pc_mux
  import pport_pkg::*;
(
  input  pc_mode_e        mode,
  input  logic [PC_W-1:0] pc_q,
  input  logic            a_intr,
  input  logic            a_bf,
  input  logic            b_intr,
  input  logic            b_bf,
  output logic [PC_W-1:0] pc_out,
  output logic [PC_W-1:0] pc_oe
);
  always_comb begin
    pc_oe  = pc_dir(mode);
    pc_out = pc_q;
    if (a_hs(mode)) begin
      pc_out[0] = a_intr;
      pc_out[1] = a_bf;
      pc_out[2] = 1'b0;
    end
    if (b_hs(mode)) begin
      pc_out[3] = b_intr;
      pc_out[4] = b_bf;
      pc_out[5] = 1'b0;
    end
  end
endmodule

// File: rtl/pport_hs.sv
module pport_hs
  import pport_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dir_a,
  input  logic              cfg_dir_b,
  input  logic [1:0]        cfg_pc_mode,
  input  logic              cfg_ien_a,
  input  logic              cfg_ien_b,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              wr_c,
  input  logic              rd_a,
  input  logic              rd_b,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pa_in,
  input  logic [PORT_W-1:0] pb_in,
  input  logic [PC_W-1:0]   pc_in,
  output logic [PORT_W-1:0] rdata_a,
  output logic [PORT_W-1:0] rdata_b,
  output logic [PC_W-1:0]   rdata_c,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe,
  output logic              bf_a,
  output logic              bf_b,
  output logic              intr_a,
  output logic              intr_b
);
  localparam int STB_A_BIT = 2;
  localparam int STB_B_BIT = 5;

  pc_mode_e mode;
  assign mode = pc_mode_e'(cfg_pc_mode);

  logic [PC_W-1:0] pc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (wr_c) pc_q <= wdata[PC_W-1:0];
  end

  logic a_fall, a_rise, b_fall, b_rise;

  stb_sync #(.SYNC_N(SYNC_N)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .stb_n(pc_in[STB_A_BIT]),
    .stb_fall(a_fall), .stb_rise(a_rise));

  stb_sync #(.SYNC_N(SYNC_N)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .stb_n(pc_in[STB_B_BIT]),
    .stb_fall(b_fall), .stb_rise(b_rise));

  hs_port #(.W(PORT_W)) u_port_a (
    .clk(clk), .rst_n(rst_n), .strobed(a_hs(mode)), .dir_out(cfg_dir_a),
    .ien(cfg_ien_a), .wr(wr_a), .rd(rd_a), .wdata(wdata), .pin_in(pa_in),
    .stb_fall(a_fall), .stb_rise(a_rise), .pin_out(pa_out), .pin_oe(pa_oe),
    .rdata(rdata_a), .bf(bf_a), .intr(intr_a));

  hs_port #(.W(PORT_W)) u_port_b (
    .clk(clk), .rst_n(rst_n), .strobed(b_hs(mode)), .dir_out(cfg_dir_b),
    .ien(cfg_ien_b), .wr(wr_b), .rd(rd_b), .wdata(wdata), .pin_in(pb_in),
    .stb_fall(b_fall), .stb_rise(b_rise), .pin_out(pb_out), .pin_oe(pb_oe),
    .rdata(rdata_b), .bf(bf_b), .intr(intr_b));

  pc_mux u_pc_mux (
    .mode(mode), .pc_q(pc_q), .a_intr(intr_a), .a_bf(bf_a),
    .b_intr(intr_b), .b_bf(bf_b), .pc_out(pc_out), .pc_oe(pc_oe));

  // output pins read back their driven value, input pins read the pad
  assign rdata_c = (pc_oe & pc_out) | (~pc_oe & pc_in);

  // R5: port B flags never leave port C unless B is handshaken
  p_bpins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PCM_A_HS) |-> (pc_out[5:3] == pc_q[5:3]));
  // R4: the strobe pin of port A is never driven while A handshakes
  p_stb_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_hs(mode) |-> !pc_oe[STB_A_BIT]);
endmodule

// File: tb/pport_hs_test.sv
module pport_hs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 0, dir_b = 0, ien_a = 0, ien_b = 0;
  logic [1:0] mode = 2'b00;
  logic wr_a = 0, wr_b = 0, wr_c = 0, rd_a = 0, rd_b = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0;
  logic [5:0] pc_in = 6'h24;
  logic [7:0] rdata_a, rdata_b, pa_out, pa_oe, pb_out, pb_oe;
  logic [5:0] rdata_c, pc_out, pc_oe;
  logic bf_a, bf_b, intr_a, intr_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pport_hs uut (
    .clk(clk), .rst_n(rst_n), .cfg_dir_a(dir_a), .cfg_dir_b(dir_b),
    .cfg_pc_mode(mode), .cfg_ien_a(ien_a), .cfg_ien_b(ien_b),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .rd_a(rd_a), .rd_b(rd_b),
    .wdata(wdata), .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .rdata_a(rdata_a), .rdata_b(rdata_b), .rdata_c(rdata_c),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_out(pc_out), .pc_oe(pc_oe), .bf_a(bf_a), .bf_b(bf_b),
    .intr_a(intr_a), .intr_b(intr_b));

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_oe(input logic [1:0] m);
    logic [5:0] e;
    e = (m == 2'b11) ? 6'h3F : 6'h00;
    if (m == 2'b01 || m == 2'b10) e = 6'b000011;
    if (m == 2'b01) e = e | 6'b111000;
    if (m == 2'b10) e = e | 6'b011000;
    return e;
  endfunction

  task automatic pulse_wr(input int port, input logic [7:0] d);
    wdata = d;
    if (port == 0) wr_a = 1; else if (port == 1) wr_b = 1; else wr_c = 1;
    step();
    wr_a = 0; wr_b = 0; wr_c = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R11 reset flags", {bf_a, bf_b, intr_a, intr_b}, 4'h0);
    chk("R11 reset pc_oe", pc_oe, 6'h00);
    rst_n = 1;
    dir_a = 1; dir_b = 1;
    step();
    chk("R11 latch A cleared", pa_out, 8'h00);
    chk("R11 latch B cleared", pb_out, 8'h00);

    // R1 sweep over basic input
    dir_a = 0; dir_b = 0;
    for (int v = 0; v < 256; v += 7) begin
      pa_in = v[7:0]; pb_in = ~v[7:0];
      #1;
      chk("R1 basic read", {rdata_a, rdata_b, pa_oe, pb_oe},
          {v[7:0], ~v[7:0], 16'h0000});
    end

    // R2 sweep over basic output
    dir_a = 1; dir_b = 1;
    for (int v = 3; v < 256; v += 11) begin
      pulse_wr(0, v[7:0]);
      pulse_wr(1, 8'(v * 3));
      chk("R2 basic write", {pa_out, pa_oe, rdata_a, pb_out, pb_oe},
          {v[7:0], 8'hFF, v[7:0], 8'(v * 3), 8'hFF});
    end

    // R3 R4 R5 port C modes
    dir_a = 0; dir_b = 0;
    pulse_wr(2, 8'h2A);
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      step(2);
      chk("R3/R4/R5 pc enables", pc_oe, exp_oe(m[1:0]));
      if (m == 0) chk("R3 mode 00 reads pins", rdata_c, pc_in);
      if (m == 3) chk("R3 mode 11 drives latch", {pc_out, rdata_c}, {6'h2A, 6'h2A});
      if (m == 1) chk("R4 upper pins from latch", pc_out, 6'h2A & 6'h38);
      if (m == 2) chk("R5 pins idle flags", pc_out, 6'h00);
    end

    // R6 R7 R8 R10 strobed input on port A
    mode = 2'b10; dir_a = 0; ien_a = 1;
    step(4);
    pa_in = 8'h5C;
    pc_in[2] = 0;
    step(2);
    chk("R6 no capture before sync", bf_a, 1'b0);
    step();
    chk("R6 bf after strobe fall", {bf_a, pc_out[1], intr_a}, 3'b110);
    pa_in = 8'h00;
    #1;
    chk("R6 captured data held", rdata_a, 8'h5C);
    pc_in[2] = 1;
    step(4);
    chk("R7 intr after strobe rise", {intr_a, pc_out[0]}, 2'b11);
    ien_a = 0;
    #1;
    chk("R10 masked", intr_a, 1'b0);
    step(2);
    ien_a = 1;
    #1;
    chk("R10 request kept", intr_a, 1'b1);
    rd_a = 1; step(); rd_a = 0;
    chk("R8 read clears flags", {bf_a, intr_a}, 2'b00);

    // R9 strobed output on port B
    dir_b = 1; ien_b = 1;
    pulse_wr(1, 8'h3C);
    chk("R9 write sets bf", {bf_b, pc_out[4], intr_b, pb_out}, {3'b110, 8'h3C});
    pc_in[5] = 0;
    step(4);
    chk("R9 ack clears bf", {bf_b, intr_b}, 2'b00);
    pc_in[5] = 1;
    step(4);
    chk("R9 ack end sets intr", {intr_b, pc_out[3]}, 2'b11);
    pulse_wr(1, 8'hC3);
    chk("R9 rewrite", {bf_b, intr_b}, 2'b10);

    // R12 strobe ignored when port A is not handshaken
    mode = 2'b00; dir_a = 0;
    step(2);
    pc_in[2] = 0; pa_in = 8'hA5;
    step(4);
    chk("R12 no bf without handshake", {bf_a, rdata_a}, {1'b0, 8'hA5});
    pc_in[2] = 1;
    step(4);
    chk("R12 no intr without handshake", {bf_a, intr_a}, 2'b00);

    // R11 reset mid-operation
    mode = 2'b10; dir_b = 1;
    step(2);
    pulse_wr(1, 8'h77);
    chk("R11 precondition bf", bf_b, 1'b1);
    rst_n = 0;
    #1;
    chk("R11 reset clears", {bf_b, pb_out}, {1'b0, 8'h00});
    step();
    rst_n = 1;
    step();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule